// File: doc/BRIEF.md
# Banked-Coefficient 3x3 Matrix Multiplier

A pipelined triple dot-product engine for per-pixel colour space conversion, for example RGB to YUV and back. Each clock it accepts one triple of 12-bit two's complement integer samples on lanes A, B and C. It returns one triple of 12-bit results X, Y and Z. Each result is the weighted sum of the three samples, using that result's own row of three coefficients.

The nine coefficients are 10-bit two's complement fractions. The sign bit carries weight -1 and the LSB carries weight 2^-9, so the representable range is -1.0 to +511/512. They sit in three register sets. One set is selected per cycle by a 2-bit write enable and is loaded from three coefficient ports at once.

Set j feeds output row j. Within a set, the coefficient from port A weights lane A, port B weights lane B, and port C weights lane C. The full sum of products carries 9 fractional bits. The output drops those bits, so the result has the same integer format as the input. Nothing clamps the result. The user keeps sample and coefficient magnitudes small enough that each integer result fits in 12 bits.

Top module: `cmat3_engine`

## Requirements
- R1: While `rst_ni` is low, and after it is released, all three outputs read zero and all nine coefficients are zero. Until a set is written, samples of any value give zero results.
- R2: A write-enable code of 2'b00 leaves every coefficient unchanged, whatever the coefficient ports carry.
- R3: Write-enable codes 2'b01, 2'b10 and 2'b11 load set 1, 2 and 3 respectively from ports A, B and C together. Set 1 weights X, set 2 weights Y and set 3 weights Z. The other two sets keep their values.
- R4: A coefficient write presented in the same cycle as a sample triple is already used for that triple. The triple from the cycle before still uses the previous coefficients.
- R5: Each output row computes the sum over the three lanes of sample × coefficient: X from set 1, Y from set 2, Z from set 3.
- R6: Each output is the exact sum divided by 512, rounded toward minus infinity (fraction bits truncated). For example, 3 × 0.5 gives 1 and -3 × 0.5 gives -2.
- R7: A triple sampled on rising edge n is on the outputs right after rising edge n+4, which is five register stages. A new result follows on every edge, with no stall.
- R8: Results whose exact integer part lies within the 12-bit range come out unchanged, up to the extremes of that range. The block has no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_a_i | input | 12 | Lane A sample, two's complement integer |
| smp_b_i | input | 12 | Lane B sample, two's complement integer |
| smp_c_i | input | 12 | Lane C sample, two's complement integer |
| coef_a_i | input | 10 | Coefficient for lane A of the selected set, fraction |
| coef_b_i | input | 10 | Coefficient for lane B of the selected set, fraction |
| coef_c_i | input | 10 | Coefficient for lane C of the selected set, fraction |
| bank_we_i | input | 2 | 00 hold, 01/10/11 load set 1/2/3 |
| res_x_o | output | 12 | Row 1 result, two's complement integer |
| res_y_o | output | 12 | Row 2 result, two's complement integer |
| res_z_o | output | 12 | Row 3 result, two's complement integer |

## Verification
The overflow property assumes that the user bounds every row's full-precision sum so that its integer part fits 12 bits. Bits above the result's sign bit must then only copy the sign.

The stimulus stays inside that bound. Random coefficients are drawn from ±170/512, so the absolute values in a row add up to at most 510/512 against full-scale samples. Directed vectors use a single -1.0 coefficient only with samples of magnitude up to 2047. The zero-flush property assumes that a zero triple gives zero regardless of the coefficients, and the bench drives such triples between the impulse tests.

// File: rtl/cmat3_pkg.sv
`timescale 1ns/1ps
package cmat3_pkg;
  localparam int unsigned LANES = 3;

  typedef enum logic [1:0] {
    WE_HOLD = 2'd0,
    WE_SET1 = 2'd1,
    WE_SET2 = 2'd2,
    WE_SET3 = 2'd3
  } bank_we_e;
endpackage

// File: rtl/cmat3_coef_bank.sv
`timescale 1ns/1ps
module cmat3_coef_bank
  import cmat3_pkg::*;
#(
  parameter int unsigned COEF_W = 10
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  bank_we_e                                 we_i,
  input  logic [LANES-1:0][COEF_W-1:0]             coef_i,
  output logic [LANES-1:0][LANES-1:0][COEF_W-1:0]  bank_o
);
  // bank_o[set][lane]; set s is written by code s+1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_o <= '0;
    end else begin
      for (int s = 0; s < LANES; s++) begin
        if (we_i == bank_we_e'(s + 1)) bank_o[s] <= coef_i;
      end
    end
  end
endmodule

// File: rtl/cmat3_dot_row.sv
`timescale 1ns/1ps
module cmat3_dot_row
  import cmat3_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned COEF_W = 10,
  parameter int unsigned SUM_W  = 24
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [LANES-1:0][DATA_W-1:0]  smp_i,
  input  logic [LANES-1:0][COEF_W-1:0]  coef_i,
  output logic [SUM_W-1:0]              sum_o,
  output logic [DATA_W-1:0]             res_o
);
  localparam int unsigned PROD_W = DATA_W + COEF_W;
  localparam int unsigned FRAC_W = COEF_W - 1;

  logic [LANES-1:0][PROD_W-1:0] prod_q;
  logic signed [SUM_W-1:0]      acc;
  logic [SUM_W-1:0]             sum_q;
  logic [DATA_W-1:0]            res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        prod_q[i] <= PROD_W'($signed(smp_i[i]) * $signed(coef_i[i]));
      end
    end
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < LANES; i++) begin
      acc = acc + SUM_W'($signed(prod_q[i]));
    end
  end

  // drop the fraction: keep the integer bits only, floor rounding
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      res_q <= '0;
    end else begin
      sum_q <= acc;
      res_q <= sum_q[FRAC_W +: DATA_W];
    end
  end

  assign sum_o = sum_q;
  assign res_o = res_q;
endmodule

// File: rtl/cmat3_engine.sv
`timescale 1ns/1ps
module cmat3_engine
  import cmat3_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned COEF_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] smp_a_i,
  input  logic [DATA_W-1:0] smp_b_i,
  input  logic [DATA_W-1:0] smp_c_i,
  input  logic [COEF_W-1:0] coef_a_i,
  input  logic [COEF_W-1:0] coef_b_i,
  input  logic [COEF_W-1:0] coef_c_i,
  input  logic [1:0]        bank_we_i,
  output logic [DATA_W-1:0] res_x_o,
  output logic [DATA_W-1:0] res_y_o,
  output logic [DATA_W-1:0] res_z_o
);
  localparam int unsigned SUM_W = DATA_W + COEF_W + $clog2(LANES);

  logic [LANES-1:0][DATA_W-1:0]            smp_q;
  logic [LANES-1:0][DATA_W-1:0]            smp_al_q;
  logic [LANES-1:0][COEF_W-1:0]            coef_q;
  bank_we_e                                we_q;
  logic [LANES-1:0][LANES-1:0][COEF_W-1:0] bank_k;
  logic [LANES-1:0][SUM_W-1:0]             row_sum;
  logic [LANES-1:0][DATA_W-1:0]            row_res;

  // input registers, plus one alignment stage so a write lands with its own triple
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q    <= '0;
      smp_al_q <= '0;
      coef_q   <= '0;
      we_q     <= WE_HOLD;
    end else begin
      smp_q    <= {smp_c_i, smp_b_i, smp_a_i};
      smp_al_q <= smp_q;
      coef_q   <= {coef_c_i, coef_b_i, coef_a_i};
      we_q     <= bank_we_e'(bank_we_i);
    end
  end

  cmat3_coef_bank #(.COEF_W(COEF_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_q),
    .coef_i (coef_q),
    .bank_o (bank_k)
  );

  for (genvar r = 0; r < LANES; r++) begin : g_row
    cmat3_dot_row #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W),
      .SUM_W  (SUM_W)
    ) u_row (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .smp_i  (smp_al_q),
      .coef_i (bank_k[r]),
      .sum_o  (row_sum[r]),
      .res_o  (row_res[r])
    );
  end

  assign res_x_o = row_res[0];
  assign res_y_o = row_res[1];
  assign res_z_o = row_res[2];
endmodule

// File: rtl/cmat3_engine_chk.sv
`timescale 1ns/1ps
module cmat3_engine_chk
  import cmat3_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned COEF_W = 10,
  parameter int unsigned SUM_W  = 24
) (
  input logic                                    clk_i,
  input logic                                    rst_ni,
  input logic [DATA_W-1:0]                       smp_a_i,
  input logic [DATA_W-1:0]                       smp_b_i,
  input logic [DATA_W-1:0]                       smp_c_i,
  input bank_we_e                                we_q,
  input logic [LANES-1:0][COEF_W-1:0]            coef_q,
  input logic [LANES-1:0][LANES-1:0][COEF_W-1:0] bank_k,
  input logic [LANES-1:0][SUM_W-1:0]             row_sum,
  input logic [DATA_W-1:0]                       res_x_o,
  input logic [DATA_W-1:0]                       res_y_o,
  input logic [DATA_W-1:0]                       res_z_o
);
  localparam int unsigned HI = COEF_W - 1 + DATA_W - 1;

  // R2: hold code freezes every set
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q == WE_HOLD) |=> $stable(bank_k));

  for (genvar s = 0; s < LANES; s++) begin : g_set
    // R3: selected set takes the registered ports
    p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_q == bank_we_e'(s + 1)) |=> (bank_k[s] == $past(coef_q)));
    // R3: unselected set keeps its value
    p_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_q != bank_we_e'(s + 1)) |=> $stable(bank_k[s]));
  end

  for (genvar r = 0; r < LANES; r++) begin : g_ovf
    // R8: integer part of each row sum must fit the result width
    p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((&row_sum[r][SUM_W-1:HI]) || !(|row_sum[r][SUM_W-1:HI])));
  end

  // R7: a zero triple leaves zero results exactly five edges later
  p_zero_flush_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past((smp_a_i == '0) && (smp_b_i == '0) && (smp_c_i == '0), 5)
    |-> ((res_x_o == '0) && (res_y_o == '0) && (res_z_o == '0)));
endmodule

bind cmat3_engine cmat3_engine_chk #(
  .DATA_W (DATA_W),
  .COEF_W (COEF_W),
  .SUM_W  (SUM_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .smp_a_i (smp_a_i),
  .smp_b_i (smp_b_i),
  .smp_c_i (smp_c_i),
  .we_q    (we_q),
  .coef_q  (coef_q),
  .bank_k  (bank_k),
  .row_sum (row_sum),
  .res_x_o (res_x_o),
  .res_y_o (res_y_o),
  .res_z_o (res_z_o)
);

// File: tb/cmat3_engine_bench.sv
`timescale 1ns/1ps
module cmat3_engine_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] smp_a = '0, smp_b = '0, smp_c = '0;
  logic [9:0]  coef_a = '0, coef_b = '0, coef_c = '0;
  logic [1:0]  bank_we = '0;
  logic [11:0] res_x, res_y, res_z;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  int mk [3][3];            // model coefficients [set][lane]
  int qx[$], qy[$], qz[$];
  string qt[$];

  always #2.5 clk = ~clk;

  cmat3_engine u_cmat3_engine (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .smp_a_i   (smp_a),
    .smp_b_i   (smp_b),
    .smp_c_i   (smp_c),
    .coef_a_i  (coef_a),
    .coef_b_i  (coef_b),
    .coef_c_i  (coef_c),
    .bank_we_i (bank_we),
    .res_x_o   (res_x),
    .res_y_o   (res_y),
    .res_z_o   (res_z)
  );

  task automatic check(input string tag, input string nm, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s got %0d expected %0d", tag, nm, got, exp);
    end
  endtask

  function automatic int to_out(input int s);
    logic [11:0] v;
    v = 12'(s >>> 9);
    return int'($signed(v));
  endfunction

  // one cycle: drive, clock, update model, compare the entry due now
  task automatic step(input int a, input int b, input int c,
                      input int ka, input int kb, input int kc,
                      input int we, input string tag);
    int sm [3];
    smp_a = 12'(a); smp_b = 12'(b); smp_c = 12'(c);
    coef_a = 10'(ka); coef_b = 10'(kb); coef_c = 10'(kc);
    bank_we = 2'(we);
    @(posedge clk);
    if (we != 0) begin
      mk[we-1][0] = ka; mk[we-1][1] = kb; mk[we-1][2] = kc;
    end
    for (int r = 0; r < 3; r++) sm[r] = a*mk[r][0] + b*mk[r][1] + c*mk[r][2];
    qx.push_back(to_out(sm[0]));
    qy.push_back(to_out(sm[1]));
    qz.push_back(to_out(sm[2]));
    qt.push_back(tag);
    #1;
    if (qx.size() > 4) begin
      string t;
      t = qt.pop_front();
      check(t, "x", int'($signed(res_x)), qx.pop_front());
      check(t, "y", int'($signed(res_y)), qy.pop_front());
      check(t, "z", int'($signed(res_z)), qz.pop_front());
    end
  endtask

  function automatic int rs();
    return int'($urandom_range(0, 4095)) - 2048;
  endfunction
  function automatic int rk();
    return int'($urandom_range(0, 340)) - 170;
  endfunction

  task automatic flush(input string tag);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    for (int s = 0; s < 3; s++) for (int p = 0; p < 3; p++) mk[s][p] = 0;
    repeat (3) @(posedge clk);
    // R1: outputs cleared while in reset
    #1;
    check("R1", "x", int'($signed(res_x)), 0);
    check("R1", "y", int'($signed(res_y)), 0);
    check("R1", "z", int'($signed(res_z)), 0);
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) begin
      qx.push_back(0); qy.push_back(0); qz.push_back(0); qt.push_back("R7");
    end

    // R1: coefficients zero after reset, so nonzero samples give zero; ports idle under hold (R2)
    for (int i = 0; i < 6; i++) step(rs(), rs(), rs(), 300, -400, 77, 0, "R1");

    // R3: load diagonal 0.5 into the three sets
    step(0, 0, 0, 256, 0, 0, 1, "R3");
    step(0, 0, 0, 0, 256, 0, 2, "R3");
    step(0, 0, 0, 0, 0, 256, 3, "R3");
    step(100, -60, 8, 0, 0, 0, 0, "R3");
    // R6: floor of half-values
    step(3, -3, 1, 0, 0, 0, 0, "R6");
    step(-1, 5, -7, 0, 0, 0, 0, "R6");

    // R2: hold with busy coefficient ports
    for (int i = 0; i < 6; i++) step(rs(), rs(), rs(), rk(), rk(), rk(), 0, "R2");

    // R4: write lands with its own triple, not the one before
    step(1000, 0, 0, 0, 0, 0, 0, "R4");
    step(1000, 0, 0, -512, 0, 0, 1, "R4");
    step(-700, 0, 0, 0, 0, 0, 0, "R4");
    flush("R4");

    // R7: isolated impulse surrounded by zero triples
    step(0, 0, 0, 128, 64, 32, 1, "R7");
    step(0, 0, 0, -32, 96, 16, 2, "R7");
    step(512, 1024, -256, 0, 0, 0, 0, "R7");
    flush("R7");

    // R5: random matrices and samples with occasional rewrites
    for (int s = 1; s <= 3; s++) step(rs(), rs(), rs(), rk(), rk(), rk(), s, "R5");
    for (int i = 0; i < 60; i++) begin
      int we;
      we = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 3)) : 0;
      step(rs(), rs(), rs(), rk(), rk(), rk(), we, "R5");
    end

    // R8: range extremes with full-magnitude rows
    for (int s = 1; s <= 3; s++) step(0, 0, 0, 170, 170, 170, s, "R8");
    step(2047, 2047, 2047, 0, 0, 0, 0, "R8");
    step(-2048, -2048, -2048, 0, 0, 0, 0, "R8");
    step(0, 0, 0, -512, 0, 0, 1, "R8");
    step(2047, 0, 0, 0, 0, 0, 0, "R8");
    step(-2047, 5, 9, 0, 0, 0, 0, "R8");
    flush("R8");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R7 got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule